// File: doc/BRIEF.md
# Ring Buffer Frame Transmitter

This block moves outgoing messages into a circular byte ring that lives in a shared memory region, where a peer processor reads them. A message arrives as a start pulse with a payload length, followed by the payload on a byte stream. The block first reads the consumer's read index from the region. It then computes the free space and either rejects the message or writes a framed copy into the ring. Each frame is a 4-byte header, then the payload, then zero padding up to a 4-byte boundary.

The region has three parts. A 32-bit little-endian read index sits at offset 0. A 32-bit little-endian write index sits at offset `CACHE_ALIGN`, which must be a power of two of at least 4. The data ring of `RING_BYTES` bytes starts at offset `2*CACHE_ALIGN`. The write index only ever holds multiples of 4, so every frame store is a whole aligned 32-bit word. When a frame runs past the end of the ring, it continues at data offset 0. The new write index is published only after the last frame word is accepted. Only after that store is accepted does the block pulse a doorbell to the peer.

The payload input is a valid/ready stream. A byte moves on a cycle where both `in_valid` and `in_ready` are high. Once the producer raises `in_valid`, it must hold `in_valid` and `in_data` steady until the byte is taken. `in_ready` never depends on `in_valid`. The block applies back-pressure while it waits for the memory port, and it raises `in_ready` only for the bytes of a message that has been accepted. The memory port is a request/grant interface. A request is taken on a cycle where `mem_req` and `mem_gnt` are both high. Read data comes back on a later cycle that carries `mem_rvalid`.

Top module: `ring_frame_tx`

## Requirements
- R1: The first word of a frame is stored at data offset equal to the current write index. Its byte 0 is payload length bits 15:8, byte 1 is length bits 7:0, and bytes 2 and 3 are zero.
- R2: Payload bytes follow the header in arrival order, packed little-endian into words (byte k of a word is at data offset +k). They are followed by 0 to 3 zero bytes, so the frame occupies 4 + 4*ceil(len/4) bytes.
- R3: A frame that reaches the end of the ring continues at data offset 0.
- R4: For each message the block reads the read index at region offset 0. It accepts the message exactly when the frame size is at most (read - write - 1) modulo `RING_BYTES`.
- R5: A rejected message produces a one-cycle `reject` pulse. It causes no memory write and no doorbell, it never raises `in_ready`, and it leaves the write index unchanged.
- R6: After all frame words, the block stores the new write index, (old + frame size) modulo `RING_BYTES`, at region offset `CACHE_ALIGN`. This store is the last write of the send.
- R7: `doorbell` pulses for exactly one cycle, once per accepted message. It comes in the cycle after the write-index store is granted.
- R8: `busy` is high from the cycle after an accepted `msg_start` through the `doorbell` or `reject` cycle, then low. A `msg_start` seen while busy is ignored.
- R9: An ungranted memory request keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stable until it is granted.
- R10: `in_ready` is high only while the block is busy. Exactly `msg_len` bytes are taken for an accepted message.
- R11: After reset, `busy`, `reject`, `doorbell`, `mem_req` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_start | input | 1 | Starts a send when the block is idle |
| msg_len | input | LEN_W | Payload length in bytes, sampled with msg_start |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Block takes the payload byte |
| in_data | input | 8 | Payload byte |
| busy | output | 1 | A send is in progress |
| reject | output | 1 | One-cycle pulse: frame did not fit |
| doorbell | output | 1 | One-cycle notification to the peer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The assertions check the cycle-level rules on every cycle. A waiting memory request must stay stable. The doorbell must be a single pulse that directly follows a granted store to the write-index address, and the published index must equal the one predicted by the free-space arithmetic. `busy` must drop after each doorbell or reject, and `in_ready` must never rise while idle. Frame contents depend on whole scenarios: header byte order, payload packing, zero padding, wrap at the ring end, and the accept/reject boundary at exactly the free space and one byte beyond it. Only the bench can show these, by comparing the region's memory after each send with frames it builds itself.

// File: rtl/ring_frame_tx_pkg.sv
package ring_frame_tx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_CHECK,
    ST_HDR,
    ST_PAY,
    ST_WIDX,
    ST_BELL,
    ST_REJ
  } tx_state_e;

  // Header word as stored little-endian: byte0 = len high, byte1 = len low.
  function automatic logic [31:0] hdr_word(input logic [15:0] len);
    return {16'h0000, len[7:0], len[15:8]};
  endfunction

endpackage

// File: rtl/ring_frame_space.sv
module ring_frame_space #(
  parameter int RING_BYTES = 64,
  parameter int LEN_W      = 16,
  parameter int PTR_W      = 6
) (
  input  logic [31:0]      rd_idx,
  input  logic [31:0]      wr_idx,
  input  logic [LEN_W-1:0] len,
  output logic             fits,
  output logic [PTR_W-1:0] next_wr
);
  localparam logic [31:0] RING = 32'(RING_BYTES);

  logic [31:0] free_b;
  logic [31:0] frame_b;
  logic [31:0] sum_b;
  logic [31:0] wrap_b;

  always_comb begin
    if (rd_idx > wr_idx) free_b = rd_idx - wr_idx - 32'd1;
    else                 free_b = RING - wr_idx + rd_idx - 32'd1;
    frame_b = 32'd4 + ((32'(len) + 32'd3) & ~32'd3);
    fits    = (frame_b <= free_b);
    sum_b   = wr_idx + frame_b;
    wrap_b  = (sum_b >= RING) ? (sum_b - RING) : sum_b;
    next_wr = wrap_b[PTR_W-1:0];
  end
endmodule

// File: rtl/ring_frame_packer.sv
module ring_frame_packer #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             drain,
  output logic             word_ready,
  output logic [31:0]      word,
  output logic             done
);
  logic [LEN_W-1:0] rem_q;
  logic [2:0]       cnt_q;
  logic [31:0]      word_q;
  logic             fire;

  assign in_ready   = en && (rem_q != '0) && (cnt_q != 3'd4);
  assign fire       = in_valid && in_ready;
  assign word_ready = (cnt_q == 3'd4) || ((cnt_q != 3'd0) && (rem_q == '0));
  assign done       = (cnt_q == 3'd0) && (rem_q == '0);
  assign word       = word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      cnt_q  <= '0;
      word_q <= '0;
    end else if (load) begin
      rem_q  <= load_len;
      cnt_q  <= '0;
      word_q <= '0;
    end else if (drain) begin
      cnt_q  <= '0;
      word_q <= '0;
    end else if (fire) begin
      rem_q <= rem_q - 1'b1;
      cnt_q <= cnt_q + 3'd1;
      for (int b = 0; b < 4; b++)
        if (cnt_q[1:0] == 2'(b)) word_q[b*8 +: 8] <= in_data;
    end
  end

  // R10
  ready_has_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (rem_q == $past(rem_q) - 1'b1));
endmodule

// File: rtl/ring_frame_tx.sv
module ring_frame_tx
  import ring_frame_tx_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BASE_ADDR   = 0,
  parameter int CACHE_ALIGN = 16,
  parameter int RING_BYTES  = 64,
  parameter int LEN_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_start,
  input  logic [LEN_W-1:0]  msg_len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              busy,
  output logic              reject,
  output logic              doorbell,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata
);
  localparam int PTR_W    = $clog2(RING_BYTES);
  localparam int WR_OFF   = CACHE_ALIGN;
  localparam int DATA_OFF = 2 * CACHE_ALIGN;
  localparam logic [ADDR_W-1:0] A_RD   = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] A_WR   = ADDR_W'(BASE_ADDR + WR_OFF);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(BASE_ADDR + DATA_OFF);

  tx_state_e        state_q;
  logic [PTR_W-1:0] wr_ptr_q;
  logic [PTR_W-1:0] cur_ptr_q;
  logic [PTR_W-1:0] next_q;
  logic [LEN_W-1:0] len_q;
  logic [31:0]      rd_q;

  logic             fits;
  logic [PTR_W-1:0] next_wr;
  logic             pk_load, pk_en, pk_drain;
  logic             pk_word_ready, pk_done;
  logic [31:0]      pk_word;
  logic             granted;

  function automatic logic [PTR_W-1:0] step4(input logic [PTR_W-1:0] p);
    logic [PTR_W:0] s;
    s = {1'b0, p} + (PTR_W+1)'(4);
    return (s == (PTR_W+1)'(RING_BYTES)) ? '0 : s[PTR_W-1:0];
  endfunction

  ring_frame_space #(
    .RING_BYTES(RING_BYTES), .LEN_W(LEN_W), .PTR_W(PTR_W)
  ) u_space (
    .rd_idx (rd_q),
    .wr_idx (32'(wr_ptr_q)),
    .len    (len_q),
    .fits   (fits),
    .next_wr(next_wr)
  );

  assign pk_load  = (state_q == ST_IDLE) && msg_start;
  assign pk_en    = (state_q == ST_PAY) && !pk_word_ready;
  assign granted  = mem_req && mem_gnt;
  assign pk_drain = (state_q == ST_PAY) && granted;

  ring_frame_packer #(.LEN_W(LEN_W)) u_packer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (pk_load),
    .load_len  (msg_len),
    .en        (pk_en),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .drain     (pk_drain),
    .word_ready(pk_word_ready),
    .word      (pk_word),
    .done      (pk_done)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = A_RD;
    mem_wdata = '0;
    unique case (state_q)
      ST_RD_REQ: mem_req = 1'b1;
      ST_HDR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = A_DATA + ADDR_W'(cur_ptr_q);
        mem_wdata = hdr_word(16'(len_q));
      end
      ST_PAY: begin
        mem_req   = pk_word_ready;
        mem_we    = pk_word_ready;
        mem_addr  = A_DATA + ADDR_W'(cur_ptr_q);
        mem_wdata = pk_word;
      end
      ST_WIDX: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = A_WR;
        mem_wdata = 32'(cur_ptr_q);
      end
      default: ;
    endcase
  end

  assign busy     = (state_q != ST_IDLE);
  assign doorbell = (state_q == ST_BELL);
  assign reject   = (state_q == ST_REJ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      wr_ptr_q  <= '0;
      cur_ptr_q <= '0;
      next_q    <= '0;
      len_q     <= '0;
      rd_q      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (msg_start) begin
          len_q   <= msg_len;
          state_q <= ST_RD_REQ;
        end
        ST_RD_REQ: if (mem_gnt) state_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rvalid) begin
          rd_q    <= mem_rdata;
          state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          cur_ptr_q <= wr_ptr_q;
          next_q    <= next_wr;
          state_q   <= fits ? ST_HDR : ST_REJ;
        end
        ST_HDR: if (mem_gnt) begin
          cur_ptr_q <= step4(cur_ptr_q);
          state_q   <= ST_PAY;
        end
        ST_PAY: begin
          if (pk_done) state_q <= ST_WIDX;
          else if (granted) cur_ptr_q <= step4(cur_ptr_q);
        end
        ST_WIDX: if (mem_gnt) begin
          wr_ptr_q <= cur_ptr_q;
          state_q  <= ST_BELL;
        end
        ST_BELL: state_q <= ST_IDLE;
        ST_REJ:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  // R7
  bell_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |=> !doorbell);

  // R6
  bell_after_widx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |-> $past(mem_req && mem_gnt && mem_we && (mem_addr == A_WR)));

  // R6
  widx_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && (mem_addr == A_WR)) |-> (mem_wdata == 32'(next_q)));

  // R8
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doorbell || reject) |=> !busy);

  // R10
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);

  // R5
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> !$past(mem_req && mem_we));
endmodule

// File: tb/ring_frame_tx_tb.sv
module ring_frame_tx_tb;
  localparam int ALIGN = 16;
  localparam int RING  = 64;
  localparam int DOFF  = 2 * ALIGN;
  localparam int NW    = (DOFF + RING) / 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        msg_start = 0;
  logic [15:0] msg_len = '0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        busy, reject, doorbell;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_gnt = 0;
  logic        mem_rvalid = 0;
  logic [31:0] mem_rdata = '0;

  ring_frame_tx #(
    .ADDR_W(16), .BASE_ADDR(0), .CACHE_ALIGN(ALIGN), .RING_BYTES(RING), .LEN_W(16)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .msg_len(msg_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .busy(busy), .reject(reject), .doorbell(doorbell),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  always #4 clk = ~clk;

  logic [31:0] mem [NW];
  int          errors = 0;
  int          checks = 0;
  int          wr_cnt = 0;
  logic [15:0] last_waddr = '0;
  logic        rd_pend = 0;
  logic [31:0] rd_buf = '0;
  int          cycles = 0;
  int          model_wr = 0;
  logic [7:0]  pl [256];

  // RAM model: decisions at the falling edge, taken by the DUT at the next rising edge
  always @(negedge clk) begin
    logic g;
    mem_rvalid = 0;
    if (rd_pend) begin
      mem_rvalid = 1;
      mem_rdata  = rd_buf;
      rd_pend    = 0;
    end
    g = ($urandom % 4) != 0;
    mem_gnt = g;
    if (rst_n && mem_req && g && (int'(mem_addr >> 2) < NW)) begin
      if (mem_we) begin
        mem[mem_addr >> 2] = mem_wdata;
        wr_cnt++;
        last_waddr = mem_addr;
      end else begin
        rd_pend = 1;
        rd_buf  = mem[mem_addr >> 2];
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int free_bytes(input int rd, input int wr);
    return (rd - wr - 1 + RING) % RING;
  endfunction

  function automatic int frame_size(input int len);
    return 4 + ((len + 3) / 4) * 4;
  endfunction

  function automatic logic [7:0] ring_byte(input int off);
    logic [31:0] w;
    w = mem[(DOFF + off) / 4];
    return w[8 * (off % 4) +: 8];
  endfunction

  task automatic send(input int len, input int rd, input bit poke);
    int total, idx, cyc, bad, first_off, act, expb;
    bit fits, seen_bell, seen_rej, prev_fire, fire, busy_drop, ready_seen;
    logic [31:0] old_wr;
    total = frame_size(len);
    fits  = (total <= free_bytes(rd, model_wr));
    for (int i = DOFF / 4; i < NW; i++) mem[i] = $urandom;
    mem[0] = 32'(rd);
    old_wr = mem[ALIGN / 4];
    for (int i = 0; i < 256; i++) pl[i] = 8'($urandom);
    @(negedge clk);
    msg_start = 1;
    msg_len   = 16'(len);
    wr_cnt    = 0;
    idx = 0; cyc = 0; seen_bell = 0; seen_rej = 0; prev_fire = 0;
    busy_drop = 0; ready_seen = 0;
    @(negedge clk);
    msg_start = 0;
    while (cyc < 2000) begin
      if (!in_valid || prev_fire) begin
        in_valid = (idx < len) && (($urandom % 3) != 0);
        in_data  = pl[idx % 256];
      end
      if (!busy) busy_drop = 1;
      if (in_ready) ready_seen = 1;
      if (doorbell) begin seen_bell = 1; break; end
      if (reject)   begin seen_rej = 1;  break; end
      fire = in_valid && in_ready;
      if (poke && cyc == 3) begin msg_start = 1; msg_len = 16'd7; end
      else msg_start = 0;
      @(posedge clk);
      if (fire) idx++;
      prev_fire = fire;
      @(negedge clk);
      cyc++;
    end
    in_valid  = 0;
    msg_start = 0;
    check(seen_bell == fits && seen_rej == !fits, "R4 accept decision",
          seen_bell, fits);
    check(!busy_drop, "R8 busy held during send", busy_drop, 0);
    @(negedge clk);
    check(!doorbell && !reject && !busy, "R7/R8 single pulse then idle",
          {doorbell, reject, busy}, 0);
    if (fits) begin
      int nw;
      nw = (model_wr + total) % RING;
      check(idx == len, "R10 bytes taken", idx, len);
      check(wr_cnt == total / 4 + 1, "R6 write count", wr_cnt, total / 4 + 1);
      check(last_waddr == 16'(ALIGN), "R6 index store last", last_waddr, ALIGN);
      check(mem[ALIGN / 4] == 32'(nw), "R6 index value", mem[ALIGN / 4], nw);
      check(ring_byte(model_wr) == 8'(len >> 8) &&
            ring_byte((model_wr + 1) % RING) == 8'(len) &&
            ring_byte((model_wr + 2) % RING) == 8'h00 &&
            ring_byte((model_wr + 3) % RING) == 8'h00,
            "R1 header bytes", ring_byte(model_wr), len >> 8);
      bad = 0; first_off = 0; act = 0; expb = 0;
      for (int i = 0; i < total - 4; i++) begin
        int o;
        logic [7:0] e;
        o = (model_wr + 4 + i) % RING;
        e = (i < len) ? pl[i] : 8'h00;
        if (ring_byte(o) !== e) begin
          if (bad == 0) begin first_off = o; act = ring_byte(o); expb = e; end
          bad++;
        end
      end
      if (model_wr + total > RING)
        check(bad == 0, "R3 wrapped payload and padding", act, expb);
      else
        check(bad == 0, "R2 payload and padding", act, expb);
      model_wr = nw;
    end else begin
      check(wr_cnt == 0, "R5 no writes on reject", wr_cnt, 0);
      check(idx == 0 && !ready_seen, "R5 no bytes taken on reject", idx, 0);
      check(mem[ALIGN / 4] == old_wr, "R5 index unchanged", mem[ALIGN / 4], old_wr);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < NW; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check(!busy && !reject && !doorbell && !mem_req && !in_ready, "R11 reset state",
          {busy, reject, doorbell, mem_req, in_ready}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !mem_req && !in_ready, "R11 idle after reset",
          {busy, mem_req, in_ready}, 0);

    // Directed corners
    send(0, model_wr, 0);                      // R1 empty payload
    send(1, model_wr, 0);                      // R2 pad 3
    send(2, model_wr, 0);                      // R2 pad 2
    send(3, model_wr, 0);                      // R2 pad 1
    send(5, model_wr, 1);                      // R8 start ignored while busy
    send(12, (model_wr + 17) % RING, 0);       // R4 exact fit
    send(12, (model_wr + 16) % RING, 0);       // R5 one byte short
    send(60, model_wr, 0);                     // R5 too large for empty ring
    send(300, model_wr, 0);                    // R5 far too large
    send(56, model_wr, 0);                     // R3 largest frame, wraps
    send(40, model_wr, 0);                     // R3 wrap

    // Random mix
    for (int n = 0; n < 60; n++) begin
      int len, rd;
      len = $urandom % 50;
      rd  = (($urandom % 2) == 0) ? model_wr : int'($urandom % RING);
      send(len, rd, ($urandom % 5) == 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule